// File: doc/BRIEF.md
# Management-RAM Window Access Gate

This block decides where a memory request that falls inside the system-management RAM window is sent. Software programs four control bits through a small register port: a master enable, an "open" bit that lets ordinary (non-management) processor code reach the window, a "close" bit that steers management-mode data accesses away from DRAM, and a "lock" bit. Once lock is set it holds until reset, and the open bit stops mattering.

For each request the block is told whether the address hit the window, who issued it (processor or I/O side), whether the processor is in management mode, whether it is a code fetch or a data access, and whether it is a write-back of a dirty line. One cycle later it asserts exactly one of three results: serve from DRAM, forward to the downstream I/O path, or reject. It also flags the one illegal combination of control bits.

The control register is a two-state machine. In state CFG_UNLOCKED (the reset state), a write loads all four bits. The transition UNLOCKED→LOCKED happens when the written lock bit is 1. In state CFG_LOCKED there is no way out except reset, and a write changes only the close bit. The result register holds one of RT_NONE, RT_DRAM, RT_FWD or RT_REJ and is reloaded on every clock.

Top module: `smram_gate`

## Requirements
- R1: After reset the control readback is 0000 and dram_sel, fwd_io, reject and cfg_bad are all low.
- R2: While unlocked, a write strobe loads cfg_wdata into the register. Bit 0 is enable, bit 1 is open, bit 2 is close and bit 3 is lock. The new value is on cfg_rdata right after the strobed clock edge.
- R3: Once lock reads 1 it stays 1 until reset. While locked, a write updates only bit 2 (close), and the enable and open bits keep their values.
- R4: With enable 0, a processor request that hits the window is forwarded and never selects DRAM. This holds for write-backs too.
- R5: With enable 1 and lock 0, a processor that is not in management mode gets DRAM only when open is 1. When close is 0, a management-mode processor gets DRAM for both code and data.
- R6: With enable 1, lock 0, close 1 and open 0, a management-mode code fetch goes to DRAM, and a management-mode data access is forwarded.
- R7: enable 1, lock 0, close 1, open 1 is invalid. cfg_bad is high while the register holds it, and processor requests are forwarded and never selected to DRAM.
- R8: With lock 1 the open bit is ignored. Management-mode code goes to DRAM. Management-mode data goes to DRAM only when close is 0 and is forwarded otherwise. Non-management accesses are forwarded.
- R9: A window hit from the I/O side (req_from_cpu low) asserts reject only, whatever the control bits.
- R10: A processor write-back (req_wb high) that hits the window while enable is 1 and the configuration is valid goes to DRAM, regardless of management mode, open or close.
- R11: Results appear on the clock edge after a request with req_valid high, for one cycle. A window hit yields exactly one of dram_sel, fwd_io and reject. A miss, or a cycle with no valid request, yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Write data: bit0 enable, bit1 open, bit2 close, bit3 lock |
| cfg_rdata | output | 4 | Current control register value |
| req_valid | input | 1 | Request present this cycle |
| req_hit | input | 1 | Request address lies in the window |
| req_from_cpu | input | 1 | 1 = processor origin, 0 = I/O origin |
| req_smm | input | 1 | Processor is in management mode |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_wb | input | 1 | Request is a write-back |
| dram_sel | output | 1 | Serve request from DRAM |
| fwd_io | output | 1 | Forward request downstream |
| reject | output | 1 | Refuse request (illegal origin) |
| cfg_bad | output | 1 | Control bits hold the invalid combination |

## Verification
The control value and cfg_bad are due one edge after the write strobe, and each routing result is due exactly one edge after its request and is gone the edge after that. The bench drives every stimulus on a falling edge and samples on the next falling edge, which falls between the edge that produces a result and the edge that clears it. One check samples one further cycle to confirm that the result pulse has cleared. Each vector starts from a fresh reset, so a lock left over from one case cannot affect the next.

// File: rtl/smram_pkg.sv
package smram_pkg;
    localparam int CFG_W = 4;

    typedef struct packed {
        logic lock;   // bit 3
        logic close;  // bit 2
        logic open;   // bit 1
        logic en;     // bit 0
    } smram_cfg_t;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_DRAM = 2'd1,
        RT_FWD  = 2'd2,
        RT_REJ  = 2'd3
    } route_e;

    typedef enum logic {
        CFG_UNLOCKED = 1'b0,
        CFG_LOCKED   = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/smram_cfg_fsm.sv
module smram_cfg_fsm
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  smram_cfg_t wr_data,
    output smram_cfg_t cfg
);
    cfg_state_e state_q, state_d;
    smram_cfg_t cfg_q, cfg_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CFG_UNLOCKED;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            CFG_UNLOCKED: begin
                if (wr_en) begin
                    cfg_d = wr_data;
                    if (wr_data.lock) state_d = CFG_LOCKED;
                end
            end
            CFG_LOCKED: begin
                if (wr_en) cfg_d.close = wr_data.close;
            end
            default: state_d = CFG_UNLOCKED;
        endcase
    end

    assign cfg = cfg_q;

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_LOCKED) |=> (state_q == CFG_LOCKED));

    assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_LOCKED) |=> ($stable(cfg_q.en) && $stable(cfg_q.open) && cfg_q.lock));

    assert_lock_matches_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock == (state_q == CFG_LOCKED));
endmodule

// File: rtl/smram_route_dec.sv
module smram_route_dec
    import smram_pkg::*;
(
    input  smram_cfg_t cfg,
    input  logic       hit,
    input  logic       from_cpu,
    input  logic       smm,
    input  logic       code,
    input  logic       wb,
    output route_e     route,
    output logic       bad
);
    logic code_ok, data_ok, reach;

    always_comb begin
        bad = cfg.en && !cfg.lock && cfg.close && cfg.open;
        if (cfg.lock) begin
            code_ok = smm;
            data_ok = smm && !cfg.close;
        end else begin
            code_ok = smm || cfg.open;
            data_ok = (smm || cfg.open) && !cfg.close;
        end
        reach = code ? code_ok : data_ok;

        if (!hit)                 route = RT_NONE;
        else if (!from_cpu)       route = RT_REJ;
        else if (!cfg.en || bad)  route = RT_FWD;
        else if (wb)              route = RT_DRAM;
        else if (reach)           route = RT_DRAM;
        else                      route = RT_FWD;
    end
endmodule

// File: rtl/smram_gate.sv
module smram_gate
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic             req_hit,
    input  logic             req_from_cpu,
    input  logic             req_smm,
    input  logic             req_code,
    input  logic             req_wb,
    output logic             dram_sel,
    output logic             fwd_io,
    output logic             reject,
    output logic             cfg_bad
);
    smram_cfg_t cfg;
    route_e     route_d, route_q;
    logic       win_hit;

    assign win_hit = req_valid && req_hit;

    smram_cfg_fsm u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (smram_cfg_t'(cfg_wdata)),
        .cfg     (cfg)
    );

    smram_route_dec u_dec (
        .cfg      (cfg),
        .hit      (win_hit),
        .from_cpu (req_from_cpu),
        .smm      (req_smm),
        .code     (req_code),
        .wb       (req_wb),
        .route    (route_d),
        .bad      (cfg_bad)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= RT_NONE;
        else        route_q <= route_d;
    end

    always_comb begin
        dram_sel = 1'b0;
        fwd_io   = 1'b0;
        reject   = 1'b0;
        unique case (route_q)
            RT_NONE: ;
            RT_DRAM: dram_sel = 1'b1;
            RT_FWD:  fwd_io   = 1'b1;
            RT_REJ:  reject   = 1'b1;
            default: ;
        endcase
    end

    assign cfg_rdata = cfg;

    assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |=> ($countones({dram_sel, fwd_io, reject}) == 1));

    assert_quiet_on_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |=> !(dram_sel || fwd_io || reject));

    assert_io_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !req_from_cpu) |=> reject);

    assert_disabled_no_dram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && req_from_cpu && !cfg.en) |=> (fwd_io && !dram_sel));

    assert_bad_no_dram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && req_from_cpu && cfg_bad) |=> !dram_sel);

    assert_wb_dram_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && req_from_cpu && req_wb && cfg.en && !cfg_bad) |=> dram_sel);
endmodule

// File: tb/smram_gate_test.sv
module smram_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic [3:0] cfg_rdata;
    logic       req_valid = 1'b0, req_hit = 1'b0, req_from_cpu = 1'b0;
    logic       req_smm = 1'b0, req_code = 1'b0, req_wb = 1'b0;
    logic       dram_sel, fwd_io, reject, cfg_bad;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    smram_gate uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_hit(req_hit),
        .req_from_cpu(req_from_cpu), .req_smm(req_smm), .req_code(req_code),
        .req_wb(req_wb), .dram_sel(dram_sel), .fwd_io(fwd_io),
        .reject(reject), .cfg_bad(cfg_bad)
    );

    // {cfg[3:0] lock,close,open,en} {cpu,smm,code,wb} {expDram,expFwd,expRej,expBad}
    localparam int NV = 17;
    localparam logic [11:0] VEC [NV] = '{
        12'b0000_1110_0100, // R4 disabled, smm code
        12'b0000_1100_0100, // R4 disabled, smm data
        12'b0001_1010_0100, // R5 closed to non-smm
        12'b0011_1000_1000, // R5 open lets non-smm data in
        12'b0001_1100_1000, // R5 smm data to dram
        12'b0101_1110_1000, // R6 close: smm code to dram
        12'b0101_1100_0100, // R6 close: smm data forwarded
        12'b0101_1010_0100, // R6 close: non-smm code denied
        12'b0111_1110_0101, // R7 invalid combination
        12'b1011_1010_0100, // R8 open ignored when locked
        12'b1001_1100_1000, // R8 locked smm data, close 0
        12'b1101_1100_0100, // R8 locked smm data, close 1
        12'b1101_1110_1000, // R8 locked smm code
        12'b1111_1110_1000, // R8 locked with open and close, not invalid
        12'b0011_0110_0010, // R9 io origin rejected
        12'b0001_1001_1000, // R10 write-back to dram
        12'b0000_1001_0100  // R4 write-back with enable clear
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_cfg(input logic [3:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(input logic hit, input logic cpu, input logic smm,
                        input logic code, input logic wb);
        req_valid = 1'b1; req_hit = hit; req_from_cpu = cpu;
        req_smm = smm; req_code = code; req_wb = wb;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 reset outputs", {cfg_rdata, dram_sel, fwd_io, reject, cfg_bad}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr_cfg(VEC[i][11:8]);
            chk($sformatf("R2 vector %0d readback", i), {4'h0, cfg_rdata}, {4'h0, VEC[i][11:8]});
            send(1'b1, VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            chk($sformatf("vector %0d route/bad", i),
                {4'h0, dram_sel, fwd_io, reject, cfg_bad}, {4'h0, VEC[i][3:0]});
        end

        // R2 unlocked rewrite replaces all bits
        do_reset();
        wr_cfg(4'b0101);
        wr_cfg(4'b0010);
        chk("R2 rewrite", {4'h0, cfg_rdata}, 8'h02);

        // R3 lock sticky; only close changes
        do_reset();
        wr_cfg(4'b1001);
        wr_cfg(4'b0110);
        chk("R3 locked write", {4'h0, cfg_rdata}, 8'h0D);
        wr_cfg(4'b0000);
        chk("R3 lock held", {4'h0, cfg_rdata}, 8'h09);
        send(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);  // R8 non-smm code, locked
        chk("R8 locked non-smm forwarded", {5'h0, dram_sel, fwd_io, reject}, 8'h02);

        // R7 flag clears when combination left
        do_reset();
        wr_cfg(4'b0111);
        chk("R7 bad raised", {7'h0, cfg_bad}, 8'h01);
        wr_cfg(4'b0011);
        chk("R7 bad cleared", {7'h0, cfg_bad}, 8'h00);

        // R11 miss and no-valid cycles, pulse width
        do_reset();
        wr_cfg(4'b0011);
        send(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R11 miss quiet", {5'h0, dram_sel, fwd_io, reject}, 8'h00);
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 hit one result", {5'h0, dram_sel, fwd_io, reject}, 8'h01);
        @(negedge clk);
        chk("R11 pulse ends", {5'h0, dram_sel, fwd_io, reject}, 8'h00);
        req_hit = 1'b1; req_from_cpu = 1'b1;
        @(negedge clk);
        chk("R11 hit without valid", {5'h0, dram_sel, fwd_io, reject}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule